// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence of one SDRAM burst, one column per clock. A start request carries the first column and whether the access is a write. The generator then steps through the burst in the programmed order, raises a flag on the final beat and drops its busy flag on the clock after that. The burst shape comes from a mode word that is loaded through the same address bits a mode-register-set cycle uses. Length and ordering take effect for bursts started after the load. The CAS latency field is decoded and brought out for the read data path.

Two orderings are supported. The sequential order counts upward and wraps inside the aligned block of the burst length. The interleaved order XORs the beat number into the low column bits. A full-page burst walks all 256 columns of an 8-bit column space. It wraps from the top column to zero and runs until it is terminated or replaced by a new start. When the single-write mode bit is set, every write is one beat long and reads keep the programmed length. A terminate input cuts the running burst short.

Top module: `col_burst_gen`

## Requirements
- R1: After reset, and whenever no burst runs, busy and last read 0 and the column output reads 0. The mode after reset is length 1, sequential, CAS latency 0, single-write off.
- R2: On a clock with the load input high, the mode word is captured. The length code sits in bits 2:0: 000 gives 1 beat, 001 gives 2, 010 gives 4, 011 gives 8 and 111 gives full page. Every other code gives 1 beat. Bit 3 selects interleaved order (1) or sequential order (0). Bits 6:4 appear on the CAS latency output from the next clock. Bit 9 set enables single-write mode.
- R3: For a burst of length 2, 4 or 8 in sequential order, beat k outputs (start + k) mod L in the low log2(L) bits. The upper bits of the start column are kept.
- R4: For a burst of length 2, 4 or 8 in interleaved order, beat k outputs the start column XOR k.
- R5: A full-page burst outputs (start + k) mod 256 on beat k, whatever the value of bit 3. It never raises last and runs until it is terminated or restarted.
- R6: Last is high exactly on the final beat of a burst of fixed length. Busy is low on the clock after that beat.
- R7: With single-write mode on, a burst started as a write lasts exactly one beat. A burst started as a read keeps the programmed length.
- R8: Terminate while busy ends the burst, so busy is low on the next clock. Terminate while idle has no effect.
- R9: A start request samples the start column at a clock edge. From that edge the output shows beat 0 of the new burst, even if a burst was running or terminate was high in the same cycle.
- R10: A burst keeps the length and order that were in force when it started. A mode load during the burst, or in the same cycle as the start, affects only later bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_load_i | input | 1 | Capture mode_word_i on this clock |
| mode_word_i | input | 11 | Mode word (length, order, CAS latency, single-write) |
| cas_lat_o | output | 3 | Decoded CAS latency field |
| start_i | input | 1 | Begin a new burst |
| start_col_i | input | 8 | First column of the burst |
| start_write_i | input | 1 | The burst being started is a write |
| term_i | input | 1 | End the running burst |
| col_o | output | 8 | Column of the current beat |
| busy_o | output | 1 | A burst is running |
| last_o | output | 1 | Current beat is the final one |

## Verification
The hardest case to reach is a full-page burst that passes the wrap from column 255 to column 0 without ever raising last. The stimulus starts such a burst near the top of the column space and runs it for more than 256 clocks before it terminates it. Mode loads that land mid-burst, or in the same cycle as a start, are also driven deliberately. A cycle-level reference model then shows that the running burst keeps its captured shape.

// File: rtl/col_burst_pkg.sv
package col_burst_pkg;
  localparam int BL_LSB = 0;
  localparam int BT_BIT = 3;
  localparam int CL_LSB = 4;
  localparam int WB_BIT = 9;

  typedef enum logic [2:0] {
    BL_1    = 3'b000,
    BL_2    = 3'b001,
    BL_4    = 3'b010,
    BL_8    = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  typedef struct packed {
    logic [2:0] bl;
    logic       inter;
    logic [2:0] cas;
    logic       single_wr;
  } mode_t;
endpackage

// File: rtl/col_burst_mode.sv
module col_burst_mode
  import col_burst_pkg::*;
#(
  parameter int MODE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [MODE_W-1:0] word_i,
  output mode_t             mode_o
);
  mode_t mode_q, mode_d;
  logic  unused_word;

  assign unused_word = ^{word_i[MODE_W-1:WB_BIT+1], word_i[WB_BIT-1:CL_LSB+3]};

  always_comb begin
    mode_d.bl        = word_i[BL_LSB +: 3];
    mode_d.inter     = word_i[BT_BIT];
    mode_d.cas       = word_i[CL_LSB +: 3];
    mode_d.single_wr = word_i[WB_BIT];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= '0;
    else if (load_i) mode_q <= mode_d;
  end

  assign mode_o = mode_q;

  p_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> mode_o.cas == $past(word_i[CL_LSB +: 3]));
  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(mode_o));
endmodule

// File: rtl/col_burst_ctrl.sv
module col_burst_ctrl
  import col_burst_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic             write_i,
  input  logic             term_i,
  input  mode_t            mode_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [COL_W-1:0] beat_o,
  output logic [COL_W-1:0] mask_o,
  output logic             inter_o,
  output logic [COL_W-1:0] base_o
);
  logic             busy_q, full_q, inter_q, full_d;
  logic [COL_W-1:0] beat_q, mask_q, base_q, mask_d;

  // burst shape from the mode in force at the start edge
  always_comb begin
    full_d = 1'b0;
    case (bl_code_e'(mode_i.bl))
      BL_2:    mask_d = COL_W'(1);
      BL_4:    mask_d = COL_W'(3);
      BL_8:    mask_d = COL_W'(7);
      BL_PAGE: begin mask_d = '1; full_d = 1'b1; end
      default: mask_d = '0;
    endcase
    if (write_i && mode_i.single_wr) begin
      mask_d = '0;
      full_d = 1'b0;
    end
  end

  assign last_o = busy_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      full_q  <= 1'b0;
      inter_q <= 1'b0;
      beat_q  <= '0;
      mask_q  <= '0;
      base_q  <= '0;
    end else if (start_i) begin
      busy_q  <= 1'b1;
      full_q  <= full_d;
      inter_q <= mode_i.inter && !full_d;
      beat_q  <= '0;
      mask_q  <= mask_d;
      base_q  <= col_i;
    end else if (busy_q) begin
      if (term_i || last_o) busy_q <= 1'b0;
      else beat_q <= beat_q + COL_W'(1);
    end
  end

  assign busy_o  = busy_q;
  assign beat_o  = beat_q;
  assign mask_o  = mask_q;
  assign inter_o = inter_q;
  assign base_o  = base_q;

  p_last_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> busy_o);
  p_last_ends_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i) |=> !busy_o);
  p_term_stops_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && term_i && !start_i) |=> !busy_o);
  p_start_beat0_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (busy_o && beat_o == '0));
  p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !last_o && !term_i && !start_i) |=> beat_o == $past(beat_o) + COL_W'(1));
  p_page_seq_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && full_q) |-> (!inter_o && !last_o));
  p_single_wr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && write_i && mode_i.single_wr) |=> last_o);
  p_shape_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !start_i) |=> ($stable(mask_o) && $stable(inter_o)));
endmodule

// File: rtl/col_burst_map.sv
module col_burst_map #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             inter_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_col, int_col;

  assign seq_col = (base_i & ~mask_i) | ((base_i + beat_i) & mask_i);
  assign int_col = base_i ^ (beat_i & mask_i);
  assign col_o   = inter_i ? int_col : seq_col;
endmodule

// File: rtl/col_burst_gen.sv
module col_burst_gen
  import col_burst_pkg::*;
#(
  parameter int COL_W  = 8,
  parameter int MODE_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_load_i,
  input  logic [MODE_W-1:0] mode_word_i,
  output logic [2:0]        cas_lat_o,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              start_write_i,
  input  logic              term_i,
  output logic [COL_W-1:0]  col_o,
  output logic              busy_o,
  output logic              last_o
);
  mode_t            mode;
  logic [COL_W-1:0] beat, mask, base, col_raw;
  logic             inter;

  initial begin
    if (COL_W < 3 || MODE_W <= WB_BIT) $error("col_burst_gen: bad parameters");
  end

  col_burst_mode #(.MODE_W(MODE_W)) u_mode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (mode_load_i),
    .word_i (mode_word_i),
    .mode_o (mode)
  );

  col_burst_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .col_i   (start_col_i),
    .write_i (start_write_i),
    .term_i  (term_i),
    .mode_i  (mode),
    .busy_o  (busy_o),
    .last_o  (last_o),
    .beat_o  (beat),
    .mask_o  (mask),
    .inter_o (inter),
    .base_o  (base)
  );

  col_burst_map #(.COL_W(COL_W)) u_map (
    .base_i  (base),
    .beat_i  (beat),
    .mask_i  (mask),
    .inter_i (inter),
    .col_o   (col_raw)
  );

  assign col_o     = busy_o ? col_raw : '0;
  assign cas_lat_o = mode.cas;

  p_idle_col_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (col_o == '0 && !last_o));
  p_in_block_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (((col_o ^ base) & ~mask) == '0));
  p_first_col_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> col_o == $past(start_col_i));
endmodule

// File: tb/col_burst_gen_test.sv
module col_burst_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0;
  logic [10:0] word = '0;
  logic [2:0]  cas;
  logic        st = 1'b0;
  logic [7:0]  scol = '0;
  logic        wr = 1'b0;
  logic        tm = 1'b0;
  logic [7:0]  col;
  logic        busy, last;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  int m_busy = 0, m_beat = 0, m_len = 1, m_base = 0, m_inter = 0, m_full = 0;
  int md_bl = 0, md_inter = 0, md_cas = 0, md_sw = 0;

  always #10 clk = ~clk;

  col_burst_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_load_i(ld), .mode_word_i(word),
    .cas_lat_o(cas), .start_i(st), .start_col_i(scol), .start_write_i(wr),
    .term_i(tm), .col_o(col), .busy_o(busy), .last_o(last)
  );

  task automatic check(input int act, input int exp, input string what, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_col();
    if (!m_busy) return 0;
    if (m_full) return (m_base + m_beat) % 256;
    if (m_inter) return m_base ^ m_beat;
    return (m_base / m_len) * m_len + (m_base % m_len + m_beat) % m_len;
  endfunction

  task automatic compare(input string tag);
    int e_last;
    e_last = (m_busy && !m_full && m_beat == m_len - 1) ? 1 : 0;
    check(int'(busy), m_busy, "busy", tag);
    check(int'(last), e_last, "last", tag);
    check(int'(col), exp_col(), "col", tag);
    check(int'(cas), md_cas, "cas", tag);
  endtask

  task automatic model_edge(input bit l, input int w, input bit s, input int c, input bit wt, input bit t);
    int lastnow;
    if (s) begin
      case (md_bl)
        1: m_len = 2;
        2: m_len = 4;
        3: m_len = 8;
        7: m_len = 256;
        default: m_len = 1;
      endcase
      if (wt && md_sw != 0) m_len = 1;
      m_full = (m_len == 256) ? 1 : 0;
      m_inter = (md_inter != 0 && !m_full) ? 1 : 0;
      m_busy = 1; m_beat = 0; m_base = c;
    end else if (m_busy) begin
      lastnow = (!m_full && m_beat == m_len - 1) ? 1 : 0;
      if (t || lastnow) m_busy = 0;
      else m_beat = (m_beat + 1) % 256;
    end
    if (l) begin
      md_bl = w % 8;
      md_inter = (w / 8) % 2;
      md_cas = (w / 16) % 8;
      md_sw = (w / 512) % 2;
    end
  endtask

  task automatic apply(input bit l, input int w, input bit s, input int c,
                       input bit wt, input bit t, input string tag);
    ld = l; word = 11'(w); st = s; scol = 8'(c); wr = wt; tm = t;
    @(posedge clk);
    model_edge(l, w, s, c, wt, t);
    @(negedge clk);
    ld = 1'b0; st = 1'b0; tm = 1'b0; wr = 1'b0;
    compare(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) apply(0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic load(input int w, input string tag);
    apply(1, w, 0, 0, 0, 0, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    load(11'h002, "R2");                 // length 4 sequential
    apply(0, 0, 1, 8'h0E, 0, 0, "R3");
    idle(5, "R3");
    load(11'h00B, "R4");                 // length 8 interleaved
    apply(0, 0, 1, 8'h25, 0, 0, "R4");
    idle(9, "R4");
    load(11'h001, "R3");
    apply(0, 0, 1, 8'h07, 0, 0, "R3");
    idle(3, "R6");
    load(11'h000, "R6");
    apply(0, 0, 1, 8'h44, 0, 0, "R6");
    idle(2, "R6");

    load(11'h007, "R5");                 // full page across the wrap
    apply(0, 0, 1, 8'hFD, 0, 0, "R5");
    idle(260, "R5");
    apply(0, 0, 0, 0, 0, 1, "R8");
    idle(2, "R5");
    load(11'h00F, "R5");                 // order bit ignored on full page
    apply(0, 0, 1, 8'h12, 0, 0, "R5");
    idle(4, "R5");
    apply(0, 0, 0, 0, 0, 1, "R5");
    apply(0, 0, 0, 0, 0, 1, "R8");       // terminate while idle
    idle(1, "R8");

    load(11'h20B, "R7");
    apply(0, 0, 1, 8'h30, 1, 0, "R7");
    idle(2, "R7");
    apply(0, 0, 1, 8'h33, 0, 0, "R7");
    idle(9, "R7");
    load(11'h207, "R7");
    apply(0, 0, 1, 8'hF0, 1, 0, "R7");
    idle(2, "R7");

    load(11'h003, "R9");
    apply(0, 0, 1, 8'h10, 0, 0, "R9");
    idle(2, "R9");
    apply(0, 0, 1, 8'h55, 0, 0, "R9");
    idle(3, "R9");
    apply(0, 0, 1, 8'h5A, 0, 1, "R9");   // start beats terminate
    idle(9, "R9");

    apply(0, 0, 1, 8'h60, 0, 0, "R10");
    idle(1, "R10");
    load(11'h009, "R10");
    idle(8, "R10");
    apply(1, 11'h002, 1, 8'h21, 0, 0, "R10");
    idle(3, "R10");
    apply(0, 0, 1, 8'h21, 0, 0, "R10");
    idle(5, "R10");

    load(11'h00B, "R8");
    apply(0, 0, 1, 8'h40, 0, 0, "R8");
    idle(2, "R8");
    apply(0, 0, 0, 0, 0, 1, "R8");
    idle(2, "R8");

    load(11'h004, "R2");                 // reserved length code
    apply(0, 0, 1, 8'h09, 0, 0, "R2");
    idle(2, "R2");
    load(11'h035, "R2");
    idle(1, "R2");
    load(11'h070, "R2");
    idle(1, "R1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule